// File: doc/BRIEF.md
# Serial Memory Read Slave

This block is the serial front end of a 32K x 8 byte-wide memory. A bus master selects it with an active-low chip select, shifts in an 8-bit instruction and, for an array read, a 16-bit address, both most significant bit first. The block then returns bytes on its serial output for as long as the select stays low. It serves three reads: the main array, a separate 64-byte identification page, and the status byte. The status byte can be read at any time, including while an internal write cycle is running.

The serial clock, select and data input are brought into the system clock domain through two-stage synchronisers, and edges are detected there. The system clock must run at least four times faster than the serial clock. The stored bytes sit behind a synchronous read port with one cycle of latency, driven by the block. Each byte is fetched one byte ahead of when it is sent, so the next byte is always ready at the byte boundary. Both idle levels of the serial clock are accepted: clock low when idle, and clock high when idle.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset the serial output enable `so_oe` and the fetch strobe `mem_rd` are both 0.
- R2: Instructions are 8 bits, shifted in MSB first and sampled on rising serial-clock edges. Value 8'h03 is the array read and value 8'h05 is the status read.
- R3: After an array read, the block takes a 16-bit address MSB first. Address bit 15 is ignored and bits 14:0 select the byte. On the first falling serial-clock edge after the last address bit, `so_oe` rises and the byte at that address starts to appear on `so_data`, MSB first, changing only after falling edges.
- R4: While the select stays low, the byte address advances by one after every byte. Address 16'h7FFF is followed by 16'h0000.
- R5: If `idp_en` is 1 when the last address bit arrives, the read targets the identification page instead of the main array: `mem_idp` is 1, only address bits 5:0 are used, and after offset 63 the read continues at offset 0.
- R6: A status read returns the byte {`stat_flags`[5:0], `idp_en`, `wr_busy`}, so bit 0 is the ready bit and reads 1 while `wr_busy` is 1. The status read works while `wr_busy` is 1. If clocking continues, the status byte repeats, sampled afresh at the start of each byte.
- R7: After any other instruction value, `so_oe` stays 0 and later input bits are ignored until the select rises.
- R8: While `spi_cs_n` is 1, `so_oe` is 0. A rising select ends the current transfer and resets the bit count, so the next transfer starts again with an instruction.
- R9: Transfers give the same results with the serial clock idling low and with it idling high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from master |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from master |
| so_data | output | 1 | Serial data to master |
| so_oe | output | 1 | Output enable for so_data (0 = high impedance) |
| mem_rd | output | 1 | One-cycle fetch strobe to storage |
| mem_idp | output | 1 | Fetch targets the identification page |
| mem_addr | output | 15 | Fetch address |
| mem_rdata | input | 8 | Fetched byte, valid one cycle after mem_rd |
| wr_busy | input | 1 | Internal write cycle in progress |
| idp_en | input | 1 | Status bit selecting the identification page |
| stat_flags | input | 6 | Remaining status bits 7:2 |

## Verification
Two actions share one falling serial-clock edge: the pre-fetched byte is loaded into the output shifter, and the fetch of the following byte is issued. If either comes a cycle early or late, a byte repeats or is skipped. The bench triggers this on every byte boundary of long streams, including the main-array wrap from 7FFF to 0000 and the identification-page wrap from offset 63 to 0. Every received byte is checked against a value computed from the address. The same edge also samples `wr_busy` for the status byte, so the bench changes the busy level between two status bytes and checks that bit 0 follows it.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_ADR,
      PH_ARRAY,
      PH_STATUS,
      PH_DEAF
   } spi_phase_t;

   localparam logic [7:0] CMD_ARRAY_RD  = 8'h03;
   localparam logic [7:0] CMD_STATUS_RD = 8'h05;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int              WIDTH   = 3,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_pin_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/spi_read_ptr.sv
module spi_read_ptr #(
   parameter int ADDR_W = 15,
   parameter int ID_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              load_idp,
   input  logic              step,
   output logic [ADDR_W-1:0] fmt,
   output logic [ADDR_W-1:0] nxt,
   output logic              idp
);

   localparam int PAD_W = ADDR_W - ID_W;

   logic [ADDR_W-1:0] cur;
   logic [ID_W-1:0]   id_inc;
   logic [ADDR_W-1:0] id_nxt;
   logic [ADDR_W-1:0] id_load;

   assign id_inc = cur[ID_W-1:0] + ID_W'(1);

   generate
      if (PAD_W < 0) begin : g_bad_width
         $error("spi_read_ptr: ID_W must not exceed ADDR_W");
      end else if (PAD_W > 0) begin : g_pad
         assign id_nxt  = {{PAD_W{1'b0}}, id_inc};
         assign id_load = {{PAD_W{1'b0}}, load_addr[ID_W-1:0]};

         p_page_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
            idp |-> (cur[ADDR_W-1:ID_W] == '0));
      end else begin : g_flat
         assign id_nxt  = id_inc;
         assign id_load = load_addr;
      end
   endgenerate

   assign fmt = load_idp ? id_load : load_addr;
   assign nxt = idp ? id_nxt : cur + ADDR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= '0;
         idp <= 1'b0;
      end else if (load) begin
         cur <= fmt;
         idp <= load_idp;
      end else if (step) begin
         cur <= nxt;
      end
   end

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   output logic         msb
);

   logic [W-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (clr)   q <= '0;
      else if (load)  q <= load_val;
      else if (shift) q <= {q[W-2:0], 1'b0};
   end

   assign msb = q[W-1];

   p_load_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr) |=> (msb == $past(load_val[W-1])));

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
   import spi_mem_pkg::*;
#(
   parameter int ADDR_W      = 15,
   parameter int ID_W        = 6,
   parameter int DATA_W      = 8,
   parameter int XADDR_W     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              so_data,
   output logic              so_oe,
   output logic              mem_rd,
   output logic              mem_idp,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              wr_busy,
   input  logic              idp_en,
   input  logic [DATA_W-3:0] stat_flags
);

   localparam int CMD_W = 8;
   localparam int CNT_W = $clog2(XADDR_W);
   localparam int BIT_W = $clog2(DATA_W);
   localparam int SH_W  = ADDR_W;

   generate
      if (DATA_W != (1 << BIT_W)) begin : g_bad_data
         $error("spi_mem_slave: DATA_W must be a power of two");
      end
      if (SH_W < CMD_W - 1 || ADDR_W >= XADDR_W) begin : g_bad_addr
         $error("spi_mem_slave: address widths inconsistent");
      end
   endgenerate

   // synchronised pins: {sck, cs_n, mosi}
   logic [2:0] pins_s;
   logic       sck_s, cs_s, mosi_s, sck_d;

   spi_pin_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STAGES),
      .RST_VAL(3'b010)
   ) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({spi_sck, spi_cs_n, spi_mosi}),
      .dout (pins_s)
   );

   assign sck_s  = pins_s[2];
   assign cs_s   = pins_s[1];
   assign mosi_s = pins_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   logic act_rise, act_fall;
   assign act_rise = sck_s & ~sck_d & ~cs_s;
   assign act_fall = ~sck_s & sck_d & ~cs_s;

   spi_phase_t        ph;
   logic [CNT_W-1:0]  cnt;
   logic [SH_W-1:0]   in_sh;
   logic [BIT_W-1:0]  bpos;
   logic              so_en_q;
   logic              rd_q;
   logic [DATA_W-1:0] pre_q;

   logic [CMD_W-1:0]  byte_in;
   logic [SH_W-1:0]   shift_in;
   logic              addr_done, sending, byte_start, rd_step;
   logic [DATA_W-1:0] status_byte;

   assign shift_in    = {in_sh[SH_W-2:0], mosi_s};
   assign byte_in     = shift_in[CMD_W-1:0];
   assign addr_done   = act_rise && (ph == PH_ADR) && (cnt == CNT_W'(XADDR_W - 1));
   assign sending     = (ph == PH_ARRAY) || (ph == PH_STATUS);
   assign byte_start  = act_fall && sending && (bpos == '0);
   assign rd_step     = byte_start && (ph == PH_ARRAY);
   assign status_byte = {stat_flags, idp_en, wr_busy};

   // phase sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_CMD;
         cnt     <= '0;
         in_sh   <= '0;
         bpos    <= '0;
         so_en_q <= 1'b0;
      end else if (cs_s) begin
         ph      <= PH_CMD;
         cnt     <= '0;
         bpos    <= '0;
         so_en_q <= 1'b0;
      end else begin
         unique case (ph)
            PH_CMD: if (act_rise) begin
               in_sh <= shift_in;
               cnt   <= cnt + CNT_W'(1);
               if (cnt == CNT_W'(CMD_W - 1)) begin
                  cnt <= '0;
                  if (byte_in == CMD_ARRAY_RD)       ph <= PH_ADR;
                  else if (byte_in == CMD_STATUS_RD) ph <= PH_STATUS;
                  else                               ph <= PH_DEAF;
               end
            end
            PH_ADR: if (act_rise) begin
               in_sh <= shift_in;
               cnt   <= cnt + CNT_W'(1);
               if (addr_done) begin
                  cnt <= '0;
                  ph  <= PH_ARRAY;
               end
            end
            PH_ARRAY, PH_STATUS: if (act_fall) begin
               bpos    <= bpos + BIT_W'(1);
               so_en_q <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   // read pointer and one-ahead fetch
   logic [ADDR_W-1:0] ptr_fmt, ptr_nxt;
   logic              ptr_idp;

   spi_read_ptr #(
      .ADDR_W(ADDR_W),
      .ID_W  (ID_W)
   ) i_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (addr_done),
      .load_addr(shift_in[ADDR_W-1:0]),
      .load_idp (idp_en),
      .step     (rd_step),
      .fmt      (ptr_fmt),
      .nxt      (ptr_nxt),
      .idp      (ptr_idp)
   );

   assign mem_rd   = addr_done | rd_step;
   assign mem_idp  = addr_done ? idp_en : ptr_idp;
   assign mem_addr = addr_done ? ptr_fmt : ptr_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= 1'b0;
         pre_q <= '0;
      end else begin
         rd_q <= mem_rd;
         if (rd_q) pre_q <= mem_rdata;
      end
   end

   // output shifter
   spi_tx_shift #(
      .W(DATA_W)
   ) i_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cs_s),
      .load    (byte_start),
      .load_val((ph == PH_STATUS) ? status_byte : pre_q),
      .shift   (act_fall && sending && (bpos != '0)),
      .msb     (so_data)
   );

   assign so_oe = so_en_q & ~spi_cs_n;

   // assertions
   p_cs_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> (ph == PH_CMD && !so_en_q && cnt == '0));

   p_deaf_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_DEAF) |-> !so_en_q);

   p_addr_to_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      addr_done |=> (ph == PH_ARRAY && !so_en_q && bpos == '0));

   p_fetch_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   p_status_nofetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_STATUS) |-> !mem_rd);

endmodule

// File: tb/test_spi_mem_slave.sv
module test_spi_mem_slave;

   localparam int HALF = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_sck = 1'b0;
   logic       spi_cs_n = 1'b1;
   logic       spi_mosi = 1'b0;
   logic       so_data, so_oe, mem_rd, mem_idp;
   logic [14:0] mem_addr;
   logic [7:0] mem_rdata = 8'h00;
   logic       wr_busy = 1'b0;
   logic       idp_en = 1'b0;
   logic [5:0] stat_flags = 6'b000000;
   logic       mode3 = 1'b0;
   logic       done = 1'b0;

   int nchk = 0;
   int nerr = 0;

   always #4 clk = ~clk;

   spi_mem_slave i_spi_mem_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .spi_sck   (spi_sck),
      .spi_cs_n  (spi_cs_n),
      .spi_mosi  (spi_mosi),
      .so_data   (so_data),
      .so_oe     (so_oe),
      .mem_rd    (mem_rd),
      .mem_idp   (mem_idp),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .wr_busy   (wr_busy),
      .idp_en    (idp_en),
      .stat_flags(stat_flags)
   );

   function automatic logic [7:0] f_main(input logic [14:0] a);
      return 8'(a * 13) ^ a[14:7];
   endfunction

   function automatic logic [7:0] f_id(input logic [5:0] a);
      return 8'h5A ^ 8'({2'b00, a} * 3);
   endfunction

   always_ff @(posedge clk)
      if (mem_rd) mem_rdata <= mem_idp ? f_id(mem_addr[5:0]) : f_main(mem_addr);

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sel_on();
      spi_sck  = mode3;
      spi_cs_n = 1'b1;
      wait_clk(HALF);
      spi_cs_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic sel_off();
      if (!mode3) begin
         spi_sck = 1'b0;
         wait_clk(HALF);
      end
      spi_cs_n = 1'b1;
      wait_clk(2 * HALF);
   endtask

   task automatic xfer_bits(input logic [7:0] tx, input int nbits,
                            output logic [7:0] rx, output logic oe_all, output logic oe_any);
      rx = 8'h00; oe_all = 1'b1; oe_any = 1'b0;
      for (int i = 7; i >= 8 - nbits; i--) begin
         spi_sck  = 1'b0;
         spi_mosi = tx[i];
         wait_clk(HALF);
         rx[i]  = so_data;
         oe_all = oe_all & so_oe;
         oe_any = oe_any | so_oe;
         spi_sck = 1'b1;
         wait_clk(HALF);
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                       output logic oe_all, output logic oe_any);
      xfer_bits(tx, 8, rx, oe_all, oe_any);
   endtask

   // array or page read of n bytes, each checked
   task automatic do_read(input logic [15:0] addr, input int n, input string req);
      logic [7:0] rx, exp;
      logic oa, oy;
      logic any_pre;
      any_pre = 1'b0;
      sel_on();
      xfer(8'h03, rx, oa, oy);        any_pre |= oy;
      xfer(addr[15:8], rx, oa, oy);   any_pre |= oy;
      xfer(addr[7:0], rx, oa, oy);    any_pre |= oy;
      check({req, " no output before data"}, {15'd0, any_pre}, 16'd0);
      for (int k = 0; k < n; k++) begin
         xfer(8'h00, rx, oa, oy);
         if (idp_en) exp = f_id(6'(addr[5:0] + k));
         else        exp = f_main(15'(addr[14:0] + k));
         check(req, {7'd0, oa, rx}, {7'd0, 1'b1, exp});
      end
      sel_off();
   endtask

   initial begin
      logic [7:0] rx;
      logic oa, oy;
      logic [7:0] st;

      wait_clk(5);
      // R1: reset state
      check("R1 oe in reset", {15'd0, so_oe}, 16'd0);
      check("R1 rd in reset", {15'd0, mem_rd}, 16'd0);
      rst_n = 1'b1;
      wait_clk(5);
      check("R1 oe after reset", {15'd0, so_oe}, 16'd0);
      check("R1 rd after reset", {15'd0, mem_rd}, 16'd0);

      // R2/R3: sweep of start addresses, mode 0
      for (int s = 0; s < 12; s++) do_read(16'(s * 16'h0A17), 2, "R3 R2 sweep mode0");

      // R3: address bit 15 ignored
      do_read(16'h8005, 2, "R3 A15 ignored");

      // R4: stream across the top of the array
      do_read(16'h7FF4, 20, "R4 wrap stream");

      // R5: identification page, wraps inside 64 bytes
      idp_en = 1'b1;
      do_read(16'h1238, 72, "R5 id page stream");
      idp_en = 1'b0;
      do_read(16'h0038, 2, "R5 main after id");

      // R6: status read with busy, bit 0 follows busy per byte
      stat_flags = 6'b101101;
      idp_en     = 1'b1;
      wr_busy    = 1'b1;
      sel_on();
      xfer(8'h05, rx, oa, oy);
      check("R6 no output during opcode", {15'd0, oy}, 16'd0);
      xfer(8'h00, st, oa, oy);
      check("R6 status busy", {7'd0, oa, st}, {7'd0, 1'b1, 8'b1011_0111});
      xfer(8'h00, st, oa, oy);
      check("R6 status repeat", {7'd0, oa, st}, {7'd0, 1'b1, 8'b1011_0111});
      wr_busy = 1'b0;
      xfer(8'h00, st, oa, oy);
      check("R6 status ready", {7'd0, oa, st}, {7'd0, 1'b1, 8'b1011_0110});
      sel_off();
      idp_en = 1'b0;
      stat_flags = 6'b010010;
      sel_on();
      xfer(8'h05, rx, oa, oy);
      xfer(8'h00, st, oa, oy);
      check("R6 status idle", {7'd0, oa, st}, {7'd0, 1'b1, 8'b0100_1000});
      sel_off();

      // R7: unknown instruction keeps output off
      sel_on();
      xfer(8'h0B, rx, oa, oy);
      for (int k = 0; k < 4; k++) begin
         xfer(8'h03, rx, oa, oy);
         check("R7 unknown opcode quiet", {15'd0, oy}, 16'd0);
      end
      sel_off();
      do_read(16'h0100, 2, "R7 recovery");

      // R8: abort in the address phase, then restart cleanly
      sel_on();
      xfer(8'h03, rx, oa, oy);
      xfer(8'h12, rx, oa, oy);
      xfer_bits(8'h34, 4, rx, oa, oy);
      sel_off();
      check("R8 oe low after abort", {15'd0, so_oe}, 16'd0);
      do_read(16'h0040, 2, "R8 restart after abort");

      // R8: abort mid data byte, output released with select
      sel_on();
      xfer(8'h03, rx, oa, oy);
      xfer(8'h00, rx, oa, oy);
      xfer(8'h10, rx, oa, oy);
      xfer_bits(8'h00, 3, rx, oa, oy);
      check("R8 oe high mid data", {15'd0, so_oe}, 16'd1);
      spi_cs_n = 1'b1;
      #1;
      check("R8 oe drops with select", {15'd0, so_oe}, 16'd0);
      wait_clk(2 * HALF);
      spi_sck = 1'b0;
      do_read(16'h0011, 1, "R8 clean after data abort");

      // R9: clock idle high
      mode3 = 1'b1;
      for (int s = 0; s < 4; s++) do_read(16'(16'h7FFE + s * 16'h1111), 3, "R9 mode3 read");
      idp_en = 1'b1;
      do_read(16'h003E, 4, "R9 mode3 id page");
      idp_en = 1'b0;
      wr_busy = 1'b1;
      stat_flags = 6'b000001;
      sel_on();
      xfer(8'h05, rx, oa, oy);
      xfer(8'h00, st, oa, oy);
      check("R9 mode3 status", {7'd0, oa, st}, {7'd0, 1'b1, 8'b0000_0101});
      sel_off();
      wr_busy = 1'b0;
      mode3 = 1'b0;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule